// File: doc/BRIEF.md
# Asynchronous Host Memory Access Port

This block lets an external host with no shared clock read and write on-chip memory through one 16-bit bus that carries both addresses and data. The host first runs an address phase. It drives a start address and a memory-type bit, then pulses the latch strobe. After that it moves data words by asserting select together with a read or write strobe. The block brings every strobe into the core clock domain through a two-flop synchronizer. It detects the edges there and makes one memory access for each transfer. The address then advances by itself, so a host can stream a run of sequential words after giving the start address only once.

There are two memory spaces. Data memory holds 16-bit words. Program memory holds 24-bit words, and each one crosses the bus in two transfers: the upper sixteen bits first, then the low eight bits in the low byte of the bus. An acknowledge output is high while the port is idle. It drops for the duration of each transfer. The host must only start an address phase or a new transfer while the acknowledge is high. A small window at the top of data memory is reserved for control registers, and this port never writes into it.

The memory side is a synchronous valid/ready port. A request stays asserted, with address, direction and write data held unchanged, until the memory raises `mem_req_ready`. The memory therefore applies back-pressure simply by holding ready low. Read data must come back on `mem_rvalid` exactly one cycle after the request is accepted. The return path has no back-pressure.

Top module: `host_mem_port`

## Requirements
- R1: While reset is held and right after it, `h_ack` is 1, `h_bus_oe` is 0 and `mem_req_valid` is 0.
- R2: On a synchronized falling edge of `h_latch`, accepted only while idle, bus bits [13:0] become the transfer address. Bus bit 15 selects the space (1 = program memory, 0 = data memory). Bit 14 is ignored.
- R3: `h_ack` falls on the third rising clock edge after the request strobes are asserted. It returns high after the access completes. A memory write or an internal-only transfer keeps it low for one cycle. A memory read keeps it low for two cycles. Each cycle that ready is held low adds one more cycle.
- R4: For a read, once `h_ack` is high again and select with read is still held, `h_bus_oe` is 1 and `h_bus_out` carries the word. A data-memory read returns the memory's bits [15:0].
- R5: Every completed data-memory transfer advances the address by one.
- R6: A program-memory write takes two transfers. The first stores the bus as bits [23:8] and makes no memory access. The second adds bus bits [7:0] and issues a single 24-bit write. The address advances only after the second transfer.
- R7: A program-memory read takes two transfers. The first issues the memory read and returns bits [23:8]. The second returns {8'h00, bits [7:0]} with no memory access. The address advances after the second transfer.
- R8: A data-memory write to an address at or above `CTRL_BASE` (default 14'h3FE0) makes no memory access. It is still acknowledged like an internal transfer, and the address still advances. Reads of that range are performed normally.
- R9: Each transfer that touches memory issues exactly one request. While ready is low, the request holds its address, direction and data unchanged.
- R10: A new address phase restarts program-word sequencing at the upper half.
- R11: Keeping the strobes asserted after a transfer completes does not start another transfer. A new assertion is required.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_sel | input | 1 | Host select, active high, asynchronous |
| h_rd | input | 1 | Host read strobe, active high, asynchronous |
| h_wr | input | 1 | Host write strobe, active high, asynchronous |
| h_latch | input | 1 | Address latch strobe; its falling edge captures the address |
| h_bus_in | input | 16 | Host bus value driven by the host (address or write data) |
| h_bus_out | output | 16 | Read data driven toward the host |
| h_bus_oe | output | 1 | Output enable for the shared bus during reads |
| h_ack | output | 1 | High when the port is idle and ready for the host |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_is_pm | output | 1 | 1 = program memory, 0 = data memory |
| mem_addr | output | 14 | Word address |
| mem_wdata | output | 24 | Write data (data-memory writes use bits [15:0]) |
| mem_rvalid | input | 1 | Read data valid, one cycle after acceptance |
| mem_rdata | input | 24 | Read data |

## Verification
Wrong internal state shows up at the ports in two main ways. A corrupted address or half-word phase appears at the very next memory request as a wrong `mem_addr` or a wrong write word. For a program-word second half it appears instead as a missing or extra request, and the reference model flags it at the handshake edge where it occurs. A sequencer stuck in the wrong state shows as a wrong acknowledge width, which is measured for every transfer. It can also show as a request appearing while the model expects none, for example for a guarded write or for strobes held after completion. Stale read holding registers appear as wrong bus data as soon as the acknowledge returns.

// File: rtl/hmp_pkg.sv
package hmp_pkg;
  localparam int unsigned HBUS_W = 16;
  localparam int unsigned PMW_W  = 24;
  localparam int unsigned LOB_W  = PMW_W - HBUS_W;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_WAIT   = 2'd2,
    ST_HOLD   = 2'd3
  } hmp_state_e;
endpackage

// File: rtl/hmp_sync.sv
module hmp_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hmp_addr_ctr.sv
module hmp_addr_ctr #(
  parameter int unsigned ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              load_pm,
  input  logic              advance,
  output logic [ADDR_W-1:0] addr,
  output logic              is_pm,
  output logic              half_lo
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr    <= '0;
      is_pm   <= 1'b0;
      half_lo <= 1'b0;
    end else if (load) begin
      addr    <= load_addr;
      is_pm   <= load_pm;
      half_lo <= 1'b0;
    end else if (advance) begin
      if (is_pm && !half_lo) begin
        half_lo <= 1'b1;
      end else begin
        half_lo <= 1'b0;
        addr    <= addr + 1'b1;
      end
    end
  end

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !advance) |=> ($stable(addr) && $stable(is_pm) && $stable(half_lo)));

  // R10
  load_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!half_lo && addr == $past(load_addr)));
endmodule

// File: rtl/hmp_ctrl.sv
module hmp_ctrl
  import hmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_rise,
  input  logic              req_wr,
  input  logic              is_pm,
  input  logic              half_lo,
  input  logic              ctrl_hit,
  input  logic [HBUS_W-1:0] bus_in,
  input  logic              mem_req_ready,
  input  logic              mem_rvalid,
  input  logic [PMW_W-1:0]  mem_rdata,
  output logic              idle,
  output logic              advance,
  output logic              mem_req_valid,
  output logic              mem_we,
  output logic [PMW_W-1:0]  mem_wdata,
  output logic [HBUS_W-1:0] bus_out
);
  hmp_state_e        state;
  logic              dir_wr;
  logic [HBUS_W-1:0] hi_hold;
  logic [LOB_W-1:0]  lo_hold;

  assign idle          = (state == ST_IDLE);
  assign mem_req_valid = (state == ST_ACCESS);
  assign mem_we        = dir_wr;
  assign advance = (state == ST_HOLD)
                || (state == ST_ACCESS && mem_req_ready && dir_wr)
                || (state == ST_WAIT && mem_rvalid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      dir_wr    <= 1'b0;
      hi_hold   <= '0;
      lo_hold   <= '0;
      mem_wdata <= '0;
      bus_out   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (req_rise) begin
            dir_wr <= req_wr;
            if (req_wr) begin
              if (is_pm && !half_lo) begin
                hi_hold <= bus_in;
                state   <= ST_HOLD;
              end else if (is_pm) begin
                mem_wdata <= {hi_hold, bus_in[LOB_W-1:0]};
                state     <= ST_ACCESS;
              end else if (ctrl_hit) begin
                state <= ST_HOLD;
              end else begin
                mem_wdata <= {{LOB_W{1'b0}}, bus_in};
                state     <= ST_ACCESS;
              end
            end else if (is_pm && half_lo) begin
              bus_out <= {{(HBUS_W-LOB_W){1'b0}}, lo_hold};
              state   <= ST_HOLD;
            end else begin
              state <= ST_ACCESS;
            end
          end
        end
        ST_ACCESS: begin
          if (mem_req_ready) state <= dir_wr ? ST_IDLE : ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rvalid) begin
            bus_out <= is_pm ? mem_rdata[PMW_W-1:LOB_W] : mem_rdata[HBUS_W-1:0];
            lo_hold <= mem_rdata[LOB_W-1:0];
            state   <= ST_IDLE;
          end
        end
        ST_HOLD: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_we) && $stable(mem_wdata)));

  // R3
  busy_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !idle);

  // R3
  detect_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rise && idle) |=> !idle);

  // R7
  lo_read_nomem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rise && idle && !req_wr && is_pm && half_lo) |=> !mem_req_valid);
endmodule

// File: rtl/host_mem_port.sv
module host_mem_port
  import hmp_pkg::*;
#(
  parameter int unsigned ADDR_W      = 14,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] CTRL_BASE = 14'h3FE0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_sel,
  input  logic              h_rd,
  input  logic              h_wr,
  input  logic              h_latch,
  input  logic [15:0]       h_bus_in,
  output logic [15:0]       h_bus_out,
  output logic              h_bus_oe,
  output logic              h_ack,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_we,
  output logic              mem_is_pm,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [23:0]       mem_wdata,
  input  logic              mem_rvalid,
  input  logic [23:0]       mem_rdata
);
  localparam int unsigned NSTB   = 4;
  localparam int unsigned TYPE_B = HBUS_W - 1;

  logic [NSTB-1:0] stb_s;
  logic sel_s, rd_s, wr_s, latch_s;
  logic req_s, req_d, latch_d;
  logic req_rise, latch_fall;
  logic idle, advance, load, half_lo, ctrl_hit;
  logic [ADDR_W-1:0] addr;
  logic is_pm;

  hmp_sync #(.W(NSTB), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({h_latch, h_wr, h_rd, h_sel}),
    .q     (stb_s)
  );

  assign {latch_s, wr_s, rd_s, sel_s} = stb_s;
  assign req_s = sel_s && (rd_s || wr_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_d   <= 1'b0;
      latch_d <= 1'b0;
    end else begin
      req_d   <= req_s;
      latch_d <= latch_s;
    end
  end

  assign req_rise   = req_s && !req_d;
  assign latch_fall = latch_d && !latch_s;
  assign load       = latch_fall && idle;
  assign ctrl_hit   = !is_pm && (addr >= CTRL_BASE);

  hmp_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_addr (h_bus_in[ADDR_W-1:0]),
    .load_pm   (h_bus_in[TYPE_B]),
    .advance   (advance),
    .addr      (addr),
    .is_pm     (is_pm),
    .half_lo   (half_lo)
  );

  hmp_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_rise      (req_rise),
    .req_wr        (wr_s),
    .is_pm         (is_pm),
    .half_lo       (half_lo),
    .ctrl_hit      (ctrl_hit),
    .bus_in        (h_bus_in),
    .mem_req_ready (mem_req_ready),
    .mem_rvalid    (mem_rvalid),
    .mem_rdata     (mem_rdata),
    .idle          (idle),
    .advance       (advance),
    .mem_req_valid (mem_req_valid),
    .mem_we        (mem_we),
    .mem_wdata     (mem_wdata),
    .bus_out       (h_bus_out)
  );

  assign h_ack     = idle;
  assign h_bus_oe  = sel_s && rd_s;
  assign mem_addr  = addr;
  assign mem_is_pm = is_pm;

  // R8
  ctrl_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_we && !mem_is_pm) |-> (mem_addr < CTRL_BASE));

  // R6
  pm_write_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_we && mem_is_pm) |-> half_lo);

  // R9
  addr_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> $stable(mem_addr));

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |-> (h_ack && !mem_req_valid));
endmodule

// File: tb/host_mem_port_bench.sv
module host_mem_port_bench;
  typedef struct packed {
    logic [13:0] a;
    logic        we;
    logic        pm;
    logic [23:0] d;
  } op_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_sel = 0, h_rd = 0, h_wr = 0, h_latch = 0;
  logic [15:0] h_bus_in = '0;
  logic [15:0] h_bus_out;
  logic h_bus_oe, h_ack;
  logic mem_req_valid, mem_req_ready, mem_we, mem_is_pm;
  logic [13:0] mem_addr;
  logic [23:0] mem_wdata;
  logic mem_rvalid = 1'b0;
  logic [23:0] mem_rdata = '0;

  int checks = 0;
  int fails = 0;
  int stall_cnt = 0;
  bit done = 0;
  op_t exp_q[$];
  logic [15:0] dm_mem [16384];
  logic [23:0] pm_mem [16384];

  logic [13:0] m_addr;
  logic        m_pm;
  logic        m_lo;
  logic [15:0] m_hi;
  logic [7:0]  m_lob;

  always #5 clk = ~clk;

  host_mem_port u_host_mem_port (
    .clk(clk), .rst_n(rst_n), .h_sel(h_sel), .h_rd(h_rd), .h_wr(h_wr),
    .h_latch(h_latch), .h_bus_in(h_bus_in), .h_bus_out(h_bus_out),
    .h_bus_oe(h_bus_oe), .h_ack(h_ack), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_we(mem_we), .mem_is_pm(mem_is_pm),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata)
  );

  assign mem_req_ready = (stall_cnt == 0);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model and per-handshake comparison against the reference queue
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (rst_n && mem_req_valid) begin
      if (stall_cnt > 0) begin
        stall_cnt <= stall_cnt - 1;
      end else if (exp_q.size() == 0) begin
        chk("R9 R11 unexpected memory request", 32'(mem_addr), 32'hFFFF_FFFF);
      end else begin
        op_t o;
        o = exp_q.pop_front();
        chk("R2 R5 request address", 32'(mem_addr), 32'(o.a));
        chk("R9 request direction", 32'(mem_we), 32'(o.we));
        chk("R2 request space", 32'(mem_is_pm), 32'(o.pm));
        if (o.we) chk("R6 R9 write data", 32'(mem_wdata), 32'(o.d));
        else begin
          mem_rdata  <= mem_is_pm ? pm_mem[mem_addr] : {8'h00, dm_mem[mem_addr]};
          mem_rvalid <= 1'b1;
        end
      end
    end
  end

  task automatic latch_addr(input bit pm, input logic [13:0] a);
    @(negedge clk);
    h_bus_in = {pm, 1'b0, a};
    h_latch = 1'b1;
    repeat (3) @(negedge clk);
    h_latch = 1'b0;
    repeat (4) @(negedge clk);
    m_addr = a; m_pm = pm; m_lo = 1'b0;
  endtask

  task automatic xfer(input bit wr, input logic [15:0] d, input int exp_low,
                      input int hold_extra, output logic [15:0] rdv);
    int low;
    @(negedge clk);
    if (wr) h_bus_in = d;
    h_sel = 1'b1;
    if (wr) h_wr = 1'b1; else h_rd = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R3 ack high before detection", 32'(h_ack), 32'd1);
    @(negedge clk);
    chk("R3 ack low on third edge", 32'(h_ack), 32'd0);
    low = 0;
    while (!h_ack && low < 100) begin
      low++;
      @(negedge clk);
    end
    chk("R3 ack low width", 32'(low), 32'(exp_low));
    rdv = h_bus_out;
    if (!wr) chk("R4 output enable during read", 32'(h_bus_oe), 32'd1);
    for (int i = 0; i < hold_extra; i++) begin
      @(negedge clk);
      chk("R11 held strobes start nothing", 32'(h_ack), 32'd1);
    end
    h_sel = 1'b0; h_rd = 1'b0; h_wr = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic host_write(input logic [15:0] d, input int stall, input int hold_extra);
    int L;
    logic [15:0] dummy;
    if (m_pm && !m_lo) begin
      m_hi = d; m_lo = 1'b1; L = 1;
    end else if (m_pm) begin
      exp_q.push_back('{a: m_addr, we: 1'b1, pm: 1'b1, d: {m_hi, d[7:0]}});
      pm_mem[m_addr] = {m_hi, d[7:0]};
      stall_cnt = stall; L = 1 + stall;
      m_lo = 1'b0; m_addr++;
    end else if (m_addr >= 14'h3FE0) begin
      L = 1; m_addr++;
    end else begin
      exp_q.push_back('{a: m_addr, we: 1'b1, pm: 1'b0, d: {8'h00, d}});
      dm_mem[m_addr] = d;
      stall_cnt = stall; L = 1 + stall;
      m_addr++;
    end
    xfer(1'b1, d, L, hold_extra, dummy);
  endtask

  task automatic host_read(input int stall, input string tag);
    int L;
    logic [15:0] exp, got;
    if (m_pm && m_lo) begin
      exp = {8'h00, m_lob}; L = 1; m_lo = 1'b0; m_addr++;
    end else begin
      exp_q.push_back('{a: m_addr, we: 1'b0, pm: m_pm, d: 24'h0});
      stall_cnt = stall; L = 2 + stall;
      if (m_pm) begin
        exp = pm_mem[m_addr][23:8]; m_lob = pm_mem[m_addr][7:0]; m_lo = 1'b1;
      end else begin
        exp = dm_mem[m_addr]; m_addr++;
      end
    end
    xfer(1'b0, 16'h0, L, 0, got);
    chk(tag, 32'(got), 32'(exp));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16384; i++) begin
      dm_mem[i] = 16'(i * 37 + 5);
      pm_mem[i] = 24'(i * 977 + 11);
    end
    m_addr = '0; m_pm = 0; m_lo = 0; m_hi = '0; m_lob = '0;
    repeat (3) @(negedge clk);
    chk("R1 ack in reset", 32'(h_ack), 32'd1);
    chk("R1 oe in reset", 32'(h_bus_oe), 32'd0);
    chk("R1 no request in reset", 32'(mem_req_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ack after reset", 32'(h_ack), 32'd1);

    // R2 R5 R3 R9: data-memory burst writes with a stalled access
    latch_addr(1'b0, 14'h0100);
    host_write(16'hA5A1, 0, 0);
    host_write(16'h5A52, 2, 0);
    host_write(16'hC3C3, 0, 0);
    // R4 R5: read the burst back with a stall
    latch_addr(1'b0, 14'h0100);
    host_read(0, "R4 data read word 0");
    host_read(1, "R4 data read word 1");
    host_read(0, "R4 data read word 2");

    // R6: program-memory writes as half pairs
    latch_addr(1'b1, 14'h0040);
    host_write(16'h1234, 0, 0);
    host_write(16'hFF56, 0, 0);
    host_write(16'hABCD, 0, 0);
    host_write(16'h00EF, 3, 0);
    // R7: program-memory reads
    latch_addr(1'b1, 14'h0040);
    host_read(0, "R7 program upper half");
    host_read(0, "R7 program low byte");
    host_read(2, "R7 program upper half next word");
    host_read(0, "R7 program low byte next word");

    // R10: new address phase restarts at the upper half
    latch_addr(1'b1, 14'h0040);
    host_read(0, "R10 upper half before relatch");
    latch_addr(1'b1, 14'h0040);
    host_read(0, "R10 upper half after relatch");

    // R8: guarded control window
    latch_addr(1'b0, 14'h3FDF);
    host_write(16'h7777, 0, 0);
    host_write(16'h8888, 0, 0);
    host_read(0, "R8 read above guarded write");
    latch_addr(1'b0, 14'h3FE0);
    host_read(0, "R8 guarded word unchanged");

    // R11: strobes held after completion
    latch_addr(1'b0, 14'h0200);
    host_write(16'h4242, 0, 6);
    latch_addr(1'b0, 14'h0200);
    host_read(0, "R11 single write landed");

    repeat (5) @(negedge clk);
    chk("R9 all expected requests issued", 32'(exp_q.size()), 32'd0);
    finish_run();
  end
endmodule